// File: doc/BRIEF.md
# Serially Loaded PRG and Work-RAM Bank Address Generator

This block sits between a CPU bus and a cartridge's program ROM and work RAM. The CPU programs four 5-bit bank registers by writing one data bit per bus write into a shift register. The registers then drive the upper program-ROM address lines and the work-RAM page lines, and the block produces the RAM chip select.

One of the registers would normally pick a character-memory bank. Here part of it is put to other uses. Two of its bits pick one of four 8KB pages in a 32KB work RAM. A third bit picks which 256KB half of a 512KB program space is visible. That half-select applies to the fixed program bank as well as to the switchable one, so each half has its own fixed bank.

The output address lines are combinational on the CPU address and the register contents. Register updates take effect on the clock edge of the committing write.

Top module: `bank_addr_gen`

## Requirements
- R1: After reset the mode field is 3 and every bank register is 0. With those values, CPU address $C000 gives prg_addr 5'h0F, $8000 gives 5'h00, ram_addr is 0, and ram_cs_n is low at $6000.
- R2: A write (cpu_wr high with cpu_addr[15]=1, cpu_d7=0) shifts cpu_d0 in, least significant bit first. The first four such writes change no output. The fifth write stores the 5-bit value into the register picked by cpu_addr[14:13] (0 mode, 1 page, 2 spare, 3 program) and empties the shift register.
- R3: A write with cpu_d7=1 empties the shift register and sets mode bits [3:2] to 3. The other mode bits and the other registers are left unchanged.
- R4: ram_addr[0] (RAM A13) equals page register bit 2, and ram_addr[1] (RAM A14) equals page register bit 3.
- R5: prg_addr[4] (A18) equals page register bit 4 at every CPU address, for both the switchable bank and the fixed bank.
- R6: prg_addr[3:0] (A17..A14) depends on mode bits [3:2]. In modes 0 and 1 it is {prog[3:1], cpu_addr[14]}. In mode 2 it is 0 at $8000-$BFFF and prog[3:0] at $C000-$FFFF. In mode 3 it is prog[3:0] at $8000-$BFFF and 4'hF at $C000-$FFFF.
- R7: Page register bits 0 and 1 have no effect on prg_addr, ram_addr or ram_cs_n.
- R8: ram_cs_n is low only when cpu_addr is in $6000-$7FFF and program register bit 4 is 0 (RAM enabled).
- R9: Loading $00 into the page register gives RAM page 0 and the lower half. Loading $18 gives RAM page 2 and the upper half, so $C000 maps to prg_addr 5'h1F.
- R10: Writes with cpu_addr[15]=0 change no register and do not move the shift register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_d0 | input | 1 | CPU data bit 0 (serial data) |
| cpu_d7 | input | 1 | CPU data bit 7 (shift clear) |
| cpu_wr | input | 1 | Write strobe, one cycle per bus write |
| prg_addr | output | 5 | Program ROM address A18..A14 |
| ram_addr | output | 2 | Work RAM address A14..A13 |
| ram_cs_n | output | 1 | Work RAM chip select, active low |

## Verification
The hardest state to reach is a shift register that holds part of a value when a clear write or a write below $8000 arrives. Only a later full five-write load shows whether the leftover bits were dropped or kept. The stimulus leaves two bits pending before issuing a clear write. It then loads a value whose low bits would be corrupted by any leftover data. It also sends full five-write bursts into the RAM window and then checks that the next real load lands intact.

// File: rtl/bag_pkg.sv
package bag_pkg;
  localparam int REG_W    = 5;
  localparam int BANK_W   = 4;
  localparam int HALF_W   = 1;
  localparam int PAGE_W   = 2;
  localparam int N_REGS   = 4;

  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_PAGE = 2'd1,
    SEL_SPARE = 2'd2,
    SEL_PROG = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    PM_WIDE_A  = 2'd0,
    PM_WIDE_B  = 2'd1,
    PM_FIX_LOW = 2'd2,
    PM_FIX_TOP = 2'd3
  } prg_mode_e;

  // reset value per register index
  function automatic logic [REG_W-1:0] reg_reset_val(int idx);
    return (idx == 0) ? REG_W'(5'h0C) : '0;
  endfunction

  // 16KB bank number within one half
  function automatic logic [BANK_W-1:0] pick_prg_bank(
      prg_mode_e mode, logic [BANK_W-1:0] sel, logic a14);
    logic [BANK_W-1:0] b;
    case (mode)
      PM_FIX_LOW: b = a14 ? sel : '0;
      PM_FIX_TOP: b = a14 ? '1 : sel;
      default:    b = {sel[BANK_W-1:1], a14};
    endcase
    return b;
  endfunction

  function automatic logic in_ram_window(logic [2:0] a_hi);
    return a_hi == 3'b011;
  endfunction
endpackage

// File: rtl/bag_serial_loader.sv
module bag_serial_loader #(
  parameter int W = bag_pkg::REG_W,
  localparam int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          d0,
  input  logic          d7,
  output logic          commit_evt,
  output logic          clear_evt,
  output logic [W-1:0]  commit_val,
  output logic [CW-1:0] bit_count
);
  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;
  logic          last_bit;

  assign last_bit   = (cnt_q == CW'(W-1));
  assign clear_evt  = wr_en & d7;
  assign commit_evt = wr_en & ~d7 & last_bit;
  assign commit_val = {d0, sh_q[W-1:1]};
  assign bit_count  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (wr_en) begin
      if (d7 || last_bit) begin
        sh_q  <= '0;
        cnt_q <= '0;
      end else begin
        sh_q  <= {d0, sh_q[W-1:1]};
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/bag_regfile.sv
module bag_regfile
  import bag_pkg::*;
#(
  parameter int W = REG_W,
  parameter int N = N_REGS,
  localparam int SW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_evt,
  input  logic              clear_evt,
  input  logic [SW-1:0]     commit_sel,
  input  logic [W-1:0]      commit_val,
  output logic [N-1:0][W-1:0] regs_q
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    if (g == 0) begin : g_mode
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          regs_q[g] <= reg_reset_val(g);
        else if (clear_evt)
          regs_q[g][3:2] <= 2'b11;
        else if (commit_evt && commit_sel == SW'(g))
          regs_q[g] <= commit_val;
      end
    end else begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          regs_q[g] <= reg_reset_val(g);
        else if (commit_evt && commit_sel == SW'(g))
          regs_q[g] <= commit_val;
      end
    end
  end
endmodule

// File: rtl/bag_prg_map.sv
module bag_prg_map
  import bag_pkg::*;
#(
  parameter int BW = BANK_W,
  parameter int HW = HALF_W
) (
  input  logic [1:0]     mode,
  input  logic [BW-1:0]  prog_sel,
  input  logic [HW-1:0]  half,
  input  logic           a14,
  output logic [HW+BW-1:0] prg_addr
);
  logic [BW-1:0] bank;
  assign bank     = pick_prg_bank(prg_mode_e'(mode), prog_sel, a14);
  assign prg_addr = {half, bank};
endmodule

// File: rtl/bag_ram_steer.sv
module bag_ram_steer
  import bag_pkg::*;
#(
  parameter int PW = PAGE_W
) (
  input  logic [PW-1:0] page_bits,
  input  logic          ram_disable,
  input  logic [2:0]    addr_hi,
  output logic [PW-1:0] ram_addr,
  output logic          ram_cs_n
);
  logic ram_ce;  // active-high enable as the mapper would drive it
  assign ram_ce   = ~ram_disable & in_ram_window(addr_hi);
  assign ram_cs_n = ~ram_ce;
  assign ram_addr = page_bits;
endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen
  import bag_pkg::*;
#(
  parameter int W  = REG_W,
  parameter int BW = BANK_W,
  parameter int HW = HALF_W,
  parameter int PW = PAGE_W,
  localparam int CW = $clog2(W),
  localparam int PAGE_LSB = 2,
  localparam int HALF_LSB = PAGE_LSB + PW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [15:0]    cpu_addr,
  input  logic           cpu_d0,
  input  logic           cpu_d7,
  input  logic           cpu_wr,
  output logic [HW+BW-1:0] prg_addr,
  output logic [PW-1:0]  ram_addr,
  output logic           ram_cs_n
);
  logic                 wr_en;
  logic                 commit_evt;
  logic                 clear_evt;
  logic [W-1:0]         commit_val;
  logic [CW-1:0]        bit_count;
  logic [1:0]           commit_sel;
  logic [N_REGS-1:0][W-1:0] regs_q;
  logic [1:0]           prg_mode;
  logic [HW-1:0]        chr0_half;
  logic [PW-1:0]        chr0_page;
  logic                 unused_bits;

  assign wr_en      = cpu_wr & cpu_addr[15];
  assign commit_sel = cpu_addr[14:13];

  bag_serial_loader #(.W(W)) u_loader (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .d0(cpu_d0), .d7(cpu_d7),
    .commit_evt(commit_evt), .clear_evt(clear_evt),
    .commit_val(commit_val), .bit_count(bit_count)
  );

  bag_regfile #(.W(W), .N(N_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .commit_evt(commit_evt), .clear_evt(clear_evt),
    .commit_sel(commit_sel), .commit_val(commit_val), .regs_q(regs_q)
  );

  assign prg_mode  = regs_q[SEL_MODE][3:2];
  assign chr0_page = regs_q[SEL_PAGE][HALF_LSB-1:PAGE_LSB];
  assign chr0_half = regs_q[SEL_PAGE][HALF_LSB+HW-1:HALF_LSB];

  bag_prg_map #(.BW(BW), .HW(HW)) u_prg (
    .mode(prg_mode), .prog_sel(regs_q[SEL_PROG][BW-1:0]),
    .half(chr0_half), .a14(cpu_addr[14]), .prg_addr(prg_addr)
  );

  bag_ram_steer #(.PW(PW)) u_ram (
    .page_bits(chr0_page), .ram_disable(regs_q[SEL_PROG][W-1]),
    .addr_hi(cpu_addr[15:13]), .ram_addr(ram_addr), .ram_cs_n(ram_cs_n)
  );

  assign unused_bits = ^{cpu_addr[12:0], regs_q[SEL_SPARE],
                         regs_q[SEL_MODE][4], regs_q[SEL_MODE][1:0],
                         regs_q[SEL_PAGE][PAGE_LSB-1:0]};
endmodule

// File: rtl/bag_checker.sv
module bag_checker #(
  parameter int W  = 5,
  parameter int CW = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_wr,
  input logic        commit_evt,
  input logic        clear_evt,
  input logic [CW-1:0] bit_count,
  input logic [1:0]  prg_mode,
  input logic        chr0_half,
  input logic [4:0]  prg_addr,
  input logic [1:0]  ram_addr,
  input logic        ram_cs_n
);
  assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_count < CW'(W));

  assert_page_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_evt |=> $stable(ram_addr));

  assert_clear_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> (prg_mode == 2'b11));

  assert_half_shared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[15] |-> (prg_addr[4] == chr0_half));

  assert_fixed_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prg_mode == 2'b11 && cpu_addr[15:14] == 2'b11) |-> (prg_addr[3:0] == 4'hF));

  assert_cs_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_cs_n |-> (cpu_addr[15:13] == 3'b011));

  assert_low_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !cpu_addr[15]) |=> ($stable(prg_mode) && $stable(ram_addr) &&
                                   $stable(bit_count)));
endmodule

bind bank_addr_gen bag_checker #(.W(W), .CW(CW)) u_bag_checker (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
  .commit_evt(commit_evt), .clear_evt(clear_evt), .bit_count(bit_count),
  .prg_mode(prg_mode), .chr0_half(chr0_half[0]), .prg_addr(prg_addr),
  .ram_addr(ram_addr), .ram_cs_n(ram_cs_n)
);

// File: tb/test_bank_addr_gen.sv
`timescale 1ns/1ps
module test_bank_addr_gen;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] cpu_addr = 16'h0000;
  logic        cpu_d0 = 0, cpu_d7 = 0, cpu_wr = 0;
  logic [4:0]  prg_addr;
  logic [1:0]  ram_addr;
  logic        ram_cs_n;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bank_addr_gen i_bank_addr_gen (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_d0(cpu_d0),
    .cpu_d7(cpu_d7), .cpu_wr(cpu_wr), .prg_addr(prg_addr),
    .ram_addr(ram_addr), .ram_cs_n(ram_cs_n)
  );

  // behavioural reference: accumulated bits plus a plain list of registers
  int m_acc, m_n, m_reg[4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc <= 0; m_n <= 0;
      m_reg[0] <= 12; m_reg[1] <= 0; m_reg[2] <= 0; m_reg[3] <= 0;
    end else if (cpu_wr && cpu_addr >= 16'h8000) begin
      int v;
      if (cpu_d7) begin
        m_acc <= 0; m_n <= 0; m_reg[0] <= m_reg[0] | 12;
      end else if (m_n == 4) begin
        v = m_acc + (cpu_d0 ? 16 : 0);
        m_reg[(cpu_addr - 16'h8000) / 16'h2000] <= v;
        m_acc <= 0; m_n <= 0;
      end else begin
        m_acc <= m_acc + (cpu_d0 ? (1 << m_n) : 0);
        m_n <= m_n + 1;
      end
    end
  end

  function automatic int exp_prg(int a);
    int mode = (m_reg[0] / 4) % 4;
    int p = m_reg[3] % 16;
    int hi = (a / 16384) % 2;
    int bank;
    if (mode < 2) bank = (p / 2) * 2 + hi;
    else if (mode == 2) bank = hi ? p : 0;
    else bank = hi ? 15 : p;
    return ((m_reg[1] / 16) % 2) * 16 + bank;
  endfunction
  function automatic int exp_ram();
    return (m_reg[1] / 4) % 4;
  endfunction
  function automatic int exp_csn(int a);
    return (a >= 16'h6000 && a < 16'h8000 && m_reg[3] < 16) ? 0 : 1;
  endfunction

  task automatic chk(string req, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h addr=%h t=%0t", req, act, expv, cpu_addr, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R6 prg_addr vs model", prg_addr, exp_prg(cpu_addr));
      chk("R4 ram_addr vs model", ram_addr, exp_ram());
      chk("R8 ram_cs_n vs model", ram_cs_n, exp_csn(cpu_addr));
    end
  end

  task automatic go(logic [15:0] a);
    @(negedge clk); cpu_addr = a; cpu_wr = 0; cpu_d7 = 0; #1;
  endtask
  task automatic wbit(logic [15:0] a, logic d0, logic d7);
    @(negedge clk); cpu_addr = a; cpu_d0 = d0; cpu_d7 = d7; cpu_wr = 1;
    @(negedge clk); cpu_wr = 0; cpu_d7 = 0;
  endtask
  task automatic load(logic [15:0] a, int v);
    for (int i = 0; i < 5; i++) wbit(a, ((v >> i) & 1) != 0, 1'b0);
  endtask

  initial begin
    #20000;
    if (!done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    go(16'hC000); chk("R1 fixed top after reset", prg_addr, 5'h0F);
    go(16'h8000); chk("R1 switchable after reset", prg_addr, 5'h00);
    go(16'h6000); chk("R1 ram page", ram_addr, 0); chk("R1 cs low", ram_cs_n, 0);

    // R9 example values
    load(16'hA000, 5'h00);
    go(16'h6000); chk("R9 $00 page", ram_addr, 0);
    go(16'hC000); chk("R9 $00 half", prg_addr, 5'h0F);
    load(16'hA000, 5'h18);
    go(16'h6000); chk("R9 $18 page", ram_addr, 2);
    go(16'hC000); chk("R9 $18 fixed top", prg_addr, 5'h1F);
    go(16'h8000); chk("R5 switchable upper half", prg_addr, 5'h10);

    // R7 low bits inert, R4 page bits
    load(16'hA000, 5'h03);
    go(16'h6000); chk("R7 ram", ram_addr, 0); chk("R7 cs", ram_cs_n, 0);
    go(16'hC000); chk("R7 prg", prg_addr, 5'h0F);
    load(16'hA000, 5'h04); go(16'h6000); chk("R4 page1", ram_addr, 1);
    load(16'hA000, 5'h08); go(16'h6000); chk("R4 page2", ram_addr, 2);
    load(16'hA000, 5'h0C); go(16'h6000); chk("R4 page3", ram_addr, 3);

    // R2 partial load holds, fifth commits (value 0x10)
    for (int i = 0; i < 4; i++) wbit(16'hA000, 1'b0, 1'b0);
    go(16'h6000); chk("R2 hold after four", ram_addr, 3);
    wbit(16'hA000, 1'b1, 1'b0);
    go(16'h6000); chk("R2 commit page", ram_addr, 0);
    go(16'hC000); chk("R2 commit half", prg_addr, 5'h1F);

    // R3 clear mid-load, mode forced to 3
    load(16'h8000, 5'h00); load(16'hE000, 5'h06);
    go(16'h8000); chk("R6 wide low", prg_addr, 5'h16);
    go(16'hC000); chk("R6 wide high", prg_addr, 5'h17);
    wbit(16'hE000, 1'b1, 1'b0); wbit(16'hE000, 1'b1, 1'b0);
    wbit(16'h8000, 1'b0, 1'b1);
    go(16'hC000); chk("R3 mode forced fixed top", prg_addr, 5'h1F);
    go(16'h8000); chk("R3 prog reg kept", prg_addr, 5'h16);
    load(16'hE000, 5'h09);
    go(16'h8000); chk("R3 shift emptied", prg_addr, 5'h19);

    // R6 mode 2
    load(16'h8000, 5'h08);
    go(16'h8000); chk("R6 fix low", prg_addr, 5'h10);
    go(16'hC000); chk("R6 switch high", prg_addr, 5'h19);

    // R8 RAM enable and window
    load(16'hE000, 5'h10);
    go(16'h6000); chk("R8 disabled", ram_cs_n, 1);
    load(16'hE000, 5'h00);
    go(16'h7FFF); chk("R8 window top", ram_cs_n, 0);
    go(16'h5FFF); chk("R8 below window", ram_cs_n, 1);
    go(16'h8000); chk("R8 above window", ram_cs_n, 1);

    // R10 writes below $8000 ignored
    load(16'h6000, 5'h1F);
    wbit(16'h7FFF, 1'b0, 1'b1);
    wbit(16'h6000, 1'b1, 1'b0); wbit(16'h6000, 1'b1, 1'b0);
    go(16'hC000); chk("R10 mode kept", prg_addr, 5'h10);
    load(16'hE000, 5'h05);
    go(16'hC000); chk("R10 shift untouched", prg_addr, 5'h15);

    // sweep, compared per clock
    for (int i = 0; i < 40; i++) begin
      load(16'h8000, (i % 4) * 4);
      load(16'hA000, (i * 5) % 32);
      load(16'hE000, (i * 3) % 32);
      go(16'h6000); go(16'h8000); go(16'hA000); go(16'hC000); go(16'hE000);
    end

    go(16'h0000);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule